// File: doc/BRIEF.md
# Task Register Load Validator

This block carries out the load of the task register. A request brings a 16-bit selector together with the current privilege level. The block first checks the selector against the global descriptor table. It then reads the 8-byte system descriptor that the selector points at, over a simple memory port. It decodes that descriptor and validates it.

When the load is accepted, the selector goes into the visible task register. The descriptor's base, limit and attribute fields go into the hidden part. In the same cycle the block writes the descriptor back to memory with its busy flag set. When any check fails, the block raises a one-cycle fault with a vector number and an error code, and memory is left as it was.

The memory port has a read latency of one cycle. Read data must be valid in the cycle that follows the cycle in which `mem_rd` is high, and it must stay valid through that cycle. While a load is in progress, the block ignores new requests. Software sees this through `busy`.

Top module: `trl_unit`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `mem_rd` and `mem_wr` are 0, and every task register output (`tr_sel`, `tr_base`, `tr_limit`, `tr_attr`) is 0.
- R2: A request with `req_cpl` other than 0 gives `fault` high in the cycle after the request edge, with `fault_vec` = 13 and `fault_code` = 0. No memory access is made.
- R3: A request at privilege 0 whose selector has bit 2 set, or index bits 15:3 equal to 0, or a last descriptor byte (index*8+7) above `tbl_limit`, gives `fault` in the cycle after the request edge. `fault_vec` is 10 and `fault_code` is the selector with bits 1:0 cleared. No read is issued.
- R4: A selector that passes R2 and R3 gives `mem_rd` high for exactly one cycle, in the cycle after the request edge, with `mem_addr` = `tbl_base` + index*8.
- R5: On success, the hidden fields are taken from the descriptor. `tr_limit` = {bits 51:48, bits 15:0}. `tr_base` = {bits 63:56, bits 39:32, bits 31:16}. `tr_attr` = {bits 55:52, access byte 47:40 with bit 1 set}.
- R6: The descriptor is rejected (vector 10, error code as in R3) unless bit 44 is 0 and the type field in bits 43:40 equals 9. A type of 11 (already busy) is also rejected.
- R7: A descriptor with bit 47 (present) clear is rejected with vector 10 and the error code as in R3.
- R8: On success, `done` and `mem_wr` are both high in the third cycle after the request edge. `mem_addr` is the same as for the read, and `mem_wdata` equals the read descriptor with bit 41 set. At that point `tr_sel` holds the full request selector.
- R9: A rejected load never asserts `mem_wr`, and it leaves all task register outputs unchanged.
- R10: A request presented while `busy` is high has no effect on memory or on the task register.
- R11: `done` and `fault` are never high together, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request, sampled only while idle |
| req_sel | input | 16 | Selector operand |
| req_cpl | input | 2 | Current privilege level of the requester |
| tbl_base | input | ADDR_W | Byte address of the global descriptor table |
| tbl_limit | input | LIM_W | Byte limit of the global descriptor table (inclusive) |
| mem_rd | output | 1 | Descriptor read strobe |
| mem_wr | output | 1 | Descriptor write strobe |
| mem_addr | output | ADDR_W | Descriptor byte address |
| mem_wdata | output | 64 | Descriptor write data |
| mem_rdata | input | 64 | Descriptor read data, valid the cycle after `mem_rd` |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Load completed, one-cycle pulse |
| fault | output | 1 | Load rejected, one-cycle pulse |
| fault_vec | output | 8 | Fault vector number, valid with `fault` |
| fault_code | output | 16 | Fault error code, valid with `fault` |
| tr_sel | output | 16 | Visible task register selector |
| tr_base | output | 32 | Hidden base address |
| tr_limit | output | 20 | Hidden segment limit |
| tr_attr | output | 12 | Hidden attributes: flags nibble and access byte |

## Verification
Two things happen in the same cycle: the update of the task register and the busy-flag write-back to memory. Both must come from one decision. The bench models the descriptor table as an array driven on the falling edge. In the cycle of `done`, it compares `mem_wr`, `mem_wdata` and the new task register fields together. One cycle later it compares the stored table entry. A second request raised in the read cycle of a load in progress checks that a new selector arriving while the validator is busy cannot slip into that shared cycle.

// File: rtl/trl_pkg.sv
package trl_pkg;

   localparam int DESC_W   = 64;
   localparam int BUSY_POS = 41;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_EVAL,
      ST_WBACK
   } trl_state_e;

   typedef struct packed {
      logic [31:0] base;
      logic [19:0] limit;
      logic [3:0]  flags;
      logic [7:0]  access;
   } tr_hidden_t;

endpackage

// File: rtl/trl_sel_check.sv
module trl_sel_check #(
   parameter int SEL_W  = 16,
   parameter int LIM_W  = 16,
   parameter int ADDR_W = 32
) (
   input  logic [1:0]        cpl,
   input  logic [SEL_W-1:2]  sel_hi,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [LIM_W-1:0]  tbl_limit,
   output logic              priv_bad,
   output logic              sel_bad,
   output logic [ADDR_W-1:0] ent_addr
);
   localparam int CMP_W = (SEL_W > LIM_W) ? SEL_W : LIM_W;

   logic [SEL_W-1:0] ent_off;
   logic [SEL_W-1:0] ent_last;
   logic             idx_zero;
   logic             local_tbl;
   logic             past_end;

   always_comb begin
      ent_off   = {sel_hi[SEL_W-1:3], 3'b000};
      ent_last  = {sel_hi[SEL_W-1:3], 3'b111};
      idx_zero  = ~|sel_hi[SEL_W-1:3];
      local_tbl = sel_hi[2];
      past_end  = CMP_W'(ent_last) > CMP_W'(tbl_limit);
      priv_bad  = (cpl != 2'd0);
      sel_bad   = local_tbl | idx_zero | past_end;
   end

   generate
      if (ADDR_W >= SEL_W) begin : g_wide_addr
         assign ent_addr = tbl_base + ADDR_W'(ent_off);
      end else begin : g_narrow_addr
         assign ent_addr = tbl_base + ent_off[ADDR_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/trl_desc_check.sv
module trl_desc_check
   import trl_pkg::*;
#(
   parameter logic [3:0] AVAIL_TYPE = 4'd9
) (
   input  logic [DESC_W-1:0] desc,
   output logic              desc_ok,
   output tr_hidden_t        hidden,
   output logic [DESC_W-1:0] wb_data
);
   logic       sys_flag;
   logic       present;
   logic [3:0] dtype;

   always_comb begin
      dtype        = desc[43:40];
      sys_flag     = desc[44];
      present      = desc[47];
      desc_ok      = !sys_flag && (dtype == AVAIL_TYPE) && present;
      wb_data      = desc | (DESC_W'(1) << BUSY_POS);
      hidden.base  = {desc[63:56], desc[39:32], desc[31:16]};
      hidden.limit = {desc[51:48], desc[15:0]};
      hidden.flags = desc[55:52];
      hidden.access = wb_data[47:40];
   end

endmodule

// File: rtl/trl_unit.sv
module trl_unit
   import trl_pkg::*;
#(
   parameter int         ADDR_W = 32,
   parameter int         LIM_W  = 16,
   parameter logic [7:0] GP_VEC = 8'd13,
   parameter logic [7:0] TS_VEC = 8'd10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [15:0]       req_sel,
   input  logic [1:0]        req_cpl,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [LIM_W-1:0]  tbl_limit,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [63:0]       mem_wdata,
   input  logic [63:0]       mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [7:0]        fault_vec,
   output logic [15:0]       fault_code,
   output logic [15:0]       tr_sel,
   output logic [31:0]       tr_base,
   output logic [19:0]       tr_limit,
   output logic [11:0]       tr_attr
);
   localparam int SEL_W = 16;

   generate
      if (LIM_W < 3) begin : g_lim_chk
         $error("LIM_W must cover at least one descriptor");
      end
      if (ADDR_W < 8) begin : g_addr_chk
         $error("ADDR_W too narrow for a descriptor table");
      end
      if (GP_VEC == TS_VEC) begin : g_vec_chk
         $error("fault vectors must differ");
      end
   endgenerate

   trl_state_e        state;
   logic [SEL_W-1:0]  cur_sel;
   logic              priv_bad;
   logic              sel_bad;
   logic [ADDR_W-1:0] ent_addr;
   logic              desc_ok;
   tr_hidden_t        hidden;
   logic [63:0]       wb_data;

   trl_sel_check #(
      .SEL_W (SEL_W),
      .LIM_W (LIM_W),
      .ADDR_W(ADDR_W)
   ) u_sel (
      .cpl      (req_cpl),
      .sel_hi   (req_sel[SEL_W-1:2]),
      .tbl_base (tbl_base),
      .tbl_limit(tbl_limit),
      .priv_bad (priv_bad),
      .sel_bad  (sel_bad),
      .ent_addr (ent_addr)
   );

   trl_desc_check u_desc (
      .desc   (mem_rdata),
      .desc_ok(desc_ok),
      .hidden (hidden),
      .wb_data(wb_data)
   );

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cur_sel    <= '0;
         mem_rd     <= 1'b0;
         mem_wr     <= 1'b0;
         mem_addr   <= '0;
         mem_wdata  <= '0;
         done       <= 1'b0;
         fault      <= 1'b0;
         fault_vec  <= '0;
         fault_code <= '0;
         tr_sel     <= '0;
         tr_base    <= '0;
         tr_limit   <= '0;
         tr_attr    <= '0;
      end else begin
         done   <= 1'b0;
         fault  <= 1'b0;
         mem_rd <= 1'b0;
         mem_wr <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  if (priv_bad) begin
                     fault      <= 1'b1;
                     fault_vec  <= GP_VEC;
                     fault_code <= '0;
                  end else if (sel_bad) begin
                     fault      <= 1'b1;
                     fault_vec  <= TS_VEC;
                     fault_code <= {req_sel[SEL_W-1:2], 2'b00};
                  end else begin
                     mem_rd   <= 1'b1;
                     mem_addr <= ent_addr;
                     cur_sel  <= req_sel;
                     state    <= ST_READ;
                  end
               end
            end
            ST_READ: begin
               state <= ST_EVAL;
            end
            ST_EVAL: begin
               if (desc_ok) begin
                  mem_wr    <= 1'b1;
                  mem_wdata <= wb_data;
                  tr_sel    <= cur_sel;
                  tr_base   <= hidden.base;
                  tr_limit  <= hidden.limit;
                  tr_attr   <= {hidden.flags, hidden.access};
                  done      <= 1'b1;
                  state     <= ST_WBACK;
               end else begin
                  fault      <= 1'b1;
                  fault_vec  <= TS_VEC;
                  fault_code <= {cur_sel[SEL_W-1:2], 2'b00};
                  state      <= ST_IDLE;
               end
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end

   // R8
   wb_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($past(mem_rd, 2) && done));

   // R8
   wb_busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> mem_wdata[BUSY_POS]);

   // R9
   fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!mem_wr && !mem_rd));

   // R11
   done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault);

   // R4
   read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (!mem_rd && $stable(mem_addr)));

   // R3
   code_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && fault_vec == TS_VEC) |-> (fault_code[1:0] == 2'b00));

   // R9
   tr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(tr_sel));

endmodule

// File: tb/sim_trl_unit.sv
`timescale 1ns/1ps
module sim_trl_unit;
   localparam logic [31:0] TBL_BASE = 32'h0000_1000;
   localparam logic [15:0] TBL_LIM  = 16'd255;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_sel = '0;
   logic [1:0]  req_cpl = '0;
   logic [31:0] tbl_base = TBL_BASE;
   logic [15:0] tbl_limit = TBL_LIM;
   logic        mem_rd, mem_wr, busy, done, fault;
   logic [31:0] mem_addr;
   logic [63:0] mem_wdata;
   logic [63:0] mem_rdata = '0;
   logic [7:0]  fault_vec;
   logic [15:0] fault_code;
   logic [15:0] tr_sel;
   logic [31:0] tr_base;
   logic [19:0] tr_limit;
   logic [11:0] tr_attr;

   logic [63:0] gdt [0:31];
   int          n_chk = 0;
   int          n_bad = 0;
   logic        finished = 1'b0;

   logic [15:0] m_sel;
   logic [31:0] m_base;
   logic [19:0] m_limit;
   logic [11:0] m_attr;

   always #4 clk = ~clk;

   trl_unit u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
      .req_cpl(req_cpl), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
      .done(done), .fault(fault), .fault_vec(fault_vec),
      .fault_code(fault_code), .tr_sel(tr_sel), .tr_base(tr_base),
      .tr_limit(tr_limit), .tr_attr(tr_attr)
   );

   always @(negedge clk) begin
      if (mem_rd) mem_rdata <= gdt[mem_addr[7:3]];
      if (mem_wr) gdt[mem_addr[7:3]] <= mem_wdata;
   end

   task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_desc(input logic [31:0] b, input logic [19:0] l,
                                           input logic [3:0] f, input logic [7:0] a);
      return {b[31:24], f, l[19:16], a, b[23:16], b[15:0], l[15:0]};
   endfunction

   // 0: privilege fault, 1: selector fault, 2: descriptor fault, 3: success
   function automatic int exp_kind(input logic [15:0] s, input logic [1:0] c,
                                   input logic [63:0] d);
      if (c != 2'd0) return 0;
      if (s[2] || s[15:3] == 13'd0 || {s[15:3], 3'b111} > TBL_LIM) return 1;
      if (!d[44] && d[43:40] == 4'd9 && d[47]) return 3;
      return 2;
   endfunction

   task automatic check_tr(input string tag);
      chk(tr_sel == m_sel, tag, 64'(tr_sel), 64'(m_sel));
      chk(tr_base == m_base, tag, 64'(tr_base), 64'(m_base));
      chk(tr_limit == m_limit, tag, 64'(tr_limit), 64'(m_limit));
      chk(tr_attr == m_attr, tag, 64'(tr_attr), 64'(m_attr));
   endtask

   task automatic do_load(input logic [15:0] s, input logic [1:0] c,
                          input logic [63:0] d, input logic inject);
      int          kind;
      logic [12:0] idx;
      logic [63:0] wb;
      string       dtag;
      idx  = s[15:3];
      if (idx < 32) gdt[idx[4:0]] = d;
      kind = exp_kind(s, c, d);
      wb   = d | (64'd1 << 41);
      dtag = (!d[44] && d[43:40] == 4'd9 && !d[47]) ? "R7" : "R6";
      @(negedge clk);
      req_valid = 1'b1; req_sel = s; req_cpl = c;
      @(negedge clk);
      req_valid = 1'b0;
      if (kind == 0) begin
         chk(fault && fault_vec == 8'd13 && fault_code == 16'd0 && !mem_rd, "R2",
             {fault, 7'd0, fault_vec, fault_code, 7'd0, mem_rd}, {1'b1, 7'd0, 8'd13, 16'd0, 8'd0});
      end else if (kind == 1) begin
         chk(fault && fault_vec == 8'd10 && fault_code == {s[15:2], 2'b00} && !mem_rd, "R3",
             {fault, 7'd0, fault_vec, fault_code, 7'd0, mem_rd},
             {1'b1, 7'd0, 8'd10, s[15:2], 2'b00, 8'd0});
      end else begin
         chk(mem_rd && busy && mem_addr == TBL_BASE + {idx, 3'b000}, "R4",
             {mem_rd, busy, 30'd0, mem_addr}, {2'b11, 30'd0, TBL_BASE + {idx, 3'b000}});
         if (inject) begin
            req_valid = 1'b1; req_sel = s ^ 16'h0008; req_cpl = 2'd0;
         end
         @(negedge clk);
         req_valid = 1'b0;
         chk(!done && !fault && !mem_rd, "R11", {done, fault, mem_rd}, 64'd0);
         @(negedge clk);
         if (kind == 3) begin
            chk(done && mem_wr && mem_wdata == wb, "R8", mem_wdata, wb);
            chk(mem_addr == TBL_BASE + {idx, 3'b000}, "R8",
                64'(mem_addr), 64'(TBL_BASE + {idx, 3'b000}));
            m_sel   = s;
            m_base  = {d[63:56], d[39:32], d[31:16]};
            m_limit = {d[51:48], d[15:0]};
            m_attr  = {d[55:52], d[47:40] | 8'h02};
            check_tr("R5");
         end else begin
            chk(fault && !mem_wr && fault_vec == 8'd10 && fault_code == {s[15:2], 2'b00}, dtag,
                {fault, mem_wr, 6'd0, fault_vec, fault_code},
                {2'b10, 6'd0, 8'd10, s[15:2], 2'b00});
         end
      end
      @(negedge clk);
      chk(!done && !fault && !mem_wr && !mem_rd, "R11", {done, fault, mem_wr, mem_rd}, 64'd0);
      if (kind == 3) begin
         chk(gdt[idx[4:0]] == wb, "R8", gdt[idx[4:0]], wb);
         if (inject) chk(tr_sel == s && !busy, "R10", 64'(tr_sel), 64'(s));
      end else begin
         if (idx < 32) chk(gdt[idx[4:0]] == d, "R9", gdt[idx[4:0]], d);
         check_tr("R9");
      end
      @(negedge clk);
      chk(!busy, "R10", 64'(busy), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] good;
      int          seed;
      for (int i = 0; i < 32; i++) gdt[i] = '0;
      m_sel = '0; m_base = '0; m_limit = '0; m_attr = '0;
      seed = $urandom(32'h5eed_0a17);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !fault && !mem_rd && !mem_wr, "R1",
          {busy, done, fault, mem_rd, mem_wr}, 64'd0);
      check_tr("R1");
      rst_n = 1'b1;
      @(negedge clk);
      good = mk_desc(32'hA1B2_C3D4, 20'h5_6789, 4'h4, 8'h89);
      do_load(16'h0028, 2'd3, good, 1'b0);                            // R2
      do_load(16'h002C, 2'd0, good, 1'b0);                            // R3 local bit
      do_load(16'h0003, 2'd0, good, 1'b0);                            // R3 index zero
      do_load(16'h0100, 2'd0, good, 1'b0);                            // R3 past limit
      do_load(16'h0028, 2'd0, good, 1'b0);                            // R5 R8
      do_load(16'h0030, 2'd0, mk_desc(32'h1, 20'h2, 4'h0, 8'h8B), 1'b0); // R6 busy type
      do_load(16'h0038, 2'd0, mk_desc(32'h3, 20'h4, 4'h0, 8'h09), 1'b0); // R7
      do_load(16'h0040, 2'd0, mk_desc(32'h5, 20'h6, 4'h0, 8'h99), 1'b0); // R6 S set
      do_load(16'h00F8, 2'd0, mk_desc(32'hFFFF_0000, 20'hF_FFFF, 4'hF, 8'hE9), 1'b0); // last entry
      do_load(16'h002B, 2'd0, mk_desc(32'h0BAD_F00D, 20'h0_0067, 4'h0, 8'hC9), 1'b1); // R10
      for (int n = 0; n < 150; n++) begin
         logic [15:0] s;
         logic [1:0]  c;
         logic [7:0]  acc;
         int          cls;
         s   = {3'b000, 5'($urandom % 40), 1'b0, ($urandom % 8 == 0), 2'($urandom)};
         s[15:3] = 13'($urandom % 40);
         c   = ($urandom % 8 == 0) ? 2'(1 + $urandom % 3) : 2'd0;
         cls = $urandom % 6;
         acc = {1'b1, 2'($urandom), 1'b0, 4'd9};
         if (cls == 3) acc[3:0] = 4'd11;
         if (cls == 4) acc[4:0] = 5'($urandom);
         if (cls == 5) acc[7] = 1'b0;
         do_load(s, c, mk_desc($urandom, 20'($urandom), 4'($urandom), acc), ($urandom % 4 == 0));
      end
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule